// File: doc/BRIEF.md
# Ingress VLAN Membership Filter

This block makes the forwarding decision for each frame entering an eight-port switch. For every frame it takes the ingress port, whether the frame carried a VLAN tag, and the VID. It then returns the VID to look up: the frame's own VID for a tagged frame, or the ingress port's default VID for an untagged one. The VLAN table answers in the same cycle with an entry valid bit, a hit flag, a member map and a filtering ID. One cycle later the block reports either a destination port map or a drop together with a reason code.

Each port holds five settings, written through a simple write strobe. The settings are a forwarding mode, a fixed port-matrix member set, a default VID, an acceptable-frame-type rule and a packed set of spanning-tree states, one per filtering ID. There are three modes. Matrix mode ignores the VLAN table. Fallback mode forwards a frame even when the ingress port is not a member of the VLAN, and sends a frame whose VID is not in the table to the matrix set. Security mode discards a frame on either of those conditions.

Top module: `vlan_ingress_filter`

## Requirements
- R1: After reset, out_valid, drop, drop_reason and dest_map are 0. Every port starts with mode 0, a matrix set of all ones, default VID 0, frame-type rule 0, and all spanning-tree states 3 (forwarding).
- R2: A decision for a frame presented with in_valid appears exactly one cycle later, with out_valid high for that one cycle only. lookup_vid, which is combinational, equals in_vid for a tagged frame and the port's default VID for an untagged frame.
- R3: Frame-type rule 1 drops untagged frames and rule 2 drops tagged frames, both with drop_reason 1. Rules 0 and 3 accept every frame.
- R4: In mode 0, and also in the reserved mode 2, the candidate map is the port's matrix set, whatever the VLAN table returns.
- R5: In mode 1, a table hit uses the entry's member map even when the ingress port is not a member. A miss uses the matrix set.
- R6: In mode 3, a miss drops the frame, and so does a hit whose member map lacks the ingress port. Both drops carry drop_reason 2. Otherwise the entry's member map is used.
- R7: The table is a hit only when both tbl_hit and tbl_entry_valid are high. The filtering ID is tbl_fid on a hit and 0 on a miss. The spanning-tree state for ID f lies at bits 2f+1:2f of the port's state word. Any state other than 3 drops the frame with drop_reason 2'd3.
- R8: The ingress port's bit is always cleared from dest_map. If the resulting map is empty, the frame is dropped with drop_reason 2.
- R9: When more than one drop condition applies, the frame-type drop (1) wins over the membership/miss drop (2), which wins over the spanning-tree drop (3). A dropped frame reports dest_map 0. A forwarded frame reports drop 0 and drop_reason 0.
- R10: A configuration write takes effect from the next frame, so a frame presented on the same clock edge as a write is decided with the old setting. The cfg_sel codes are: 0 mode (bits 1:0), 1 matrix set (bits 7:0), 2 default VID (bits 11:0), 3 frame-type rule (bits 1:0), 4 spanning-tree word (bits 15:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_port | input | 3 | Port whose setting is written |
| cfg_sel | input | 3 | Setting selector |
| cfg_data | input | 16 | Write data |
| in_valid | input | 1 | Frame descriptor valid |
| in_port | input | 3 | Ingress port |
| in_tagged | input | 1 | Frame carried a VLAN tag |
| in_vid | input | 12 | VID from the tag |
| lookup_vid | output | 12 | VID presented to the VLAN table |
| tbl_hit | input | 1 | Table found the VID |
| tbl_entry_valid | input | 1 | Valid bit of the returned entry |
| tbl_members | input | 8 | Member map of the returned entry |
| tbl_fid | input | 3 | Filtering ID of the returned entry |
| out_valid | output | 1 | Decision valid |
| drop | output | 1 | Frame is discarded |
| drop_reason | output | 2 | 0 none, 1 frame type, 2 membership/miss/empty, 3 spanning tree |
| dest_map | output | 8 | Destination port map |

## Verification
The assertions check, on every cycle, that each frame gets exactly one decision one cycle later and that no decision appears without a frame. They also check that a drop always carries a nonzero reason and an empty map, that a forwarded frame has a nonempty map and reason 0, and that the ingress port never appears in its own map. Only the bench scenarios can show which map each mode selects, how a miss falls back to filtering ID 0, how the drop reasons are ranked, and that a write landing on the same edge as a frame leaves that frame's decision unchanged.

// File: rtl/vlan_ingress_filter.sv
module vlan_ingress_filter #(
  parameter int NPORTS = 8,
  parameter int VID_W  = 12,
  parameter int FID_W  = 3,
  parameter int CFG_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NPORTS)-1:0] cfg_port,
  input  logic [2:0]                cfg_sel,
  input  logic [CFG_W-1:0]          cfg_data,
  input  logic                      in_valid,
  input  logic [$clog2(NPORTS)-1:0] in_port,
  input  logic                      in_tagged,
  input  logic [VID_W-1:0]          in_vid,
  output logic [VID_W-1:0]          lookup_vid,
  input  logic                      tbl_hit,
  input  logic                      tbl_entry_valid,
  input  logic [NPORTS-1:0]         tbl_members,
  input  logic [FID_W-1:0]          tbl_fid,
  output logic                      out_valid,
  output logic                      drop,
  output logic [1:0]                drop_reason,
  output logic [NPORTS-1:0]         dest_map
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam int STP_W  = 2 * (2 ** FID_W);

  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_MTX  = 3'd1;
  localparam logic [2:0] SEL_PVID = 3'd2;
  localparam logic [2:0] SEL_ACC  = 3'd3;
  localparam logic [2:0] SEL_STP  = 3'd4;

  localparam logic [1:0] RSN_NONE = 2'd0;
  localparam logic [1:0] RSN_TYPE = 2'd1;
  localparam logic [1:0] RSN_VLAN = 2'd2;
  localparam logic [1:0] RSN_STP  = 2'd3;

  logic [1:0]        mode_q [NPORTS];
  logic [NPORTS-1:0] mtx_q  [NPORTS];
  logic [VID_W-1:0]  pvid_q [NPORTS];
  logic [1:0]        acc_q  [NPORTS];
  logic [STP_W-1:0]  stp_q  [NPORTS];

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[g] <= 2'd0;
        mtx_q[g]  <= '1;
        pvid_q[g] <= '0;
        acc_q[g]  <= 2'd0;
        stp_q[g]  <= '1;
      end else if (cfg_we && cfg_port == PORT_W'(g)) begin
        case (cfg_sel)
          SEL_MODE: mode_q[g] <= cfg_data[1:0];
          SEL_MTX:  mtx_q[g]  <= cfg_data[NPORTS-1:0];
          SEL_PVID: pvid_q[g] <= cfg_data[VID_W-1:0];
          SEL_ACC:  acc_q[g]  <= cfg_data[1:0];
          SEL_STP:  stp_q[g]  <= cfg_data[STP_W-1:0];
          default: ;
        endcase
      end
    end
  end

  logic [1:0]        cur_mode, cur_acc, stp_state, reason;
  logic [NPORTS-1:0] cur_mtx, cand, final_map;
  logic [STP_W-1:0]  cur_stp;
  logic              found, member, type_ok, vlan_ok;
  logic [FID_W-1:0]  fid_sel;

  assign cur_mode   = mode_q[in_port];
  assign cur_acc    = acc_q[in_port];
  assign cur_mtx    = mtx_q[in_port];
  assign cur_stp    = stp_q[in_port];
  assign lookup_vid = in_tagged ? in_vid : pvid_q[in_port];

  assign found     = tbl_hit & tbl_entry_valid;
  assign member    = tbl_members[in_port];
  assign fid_sel   = found ? tbl_fid : '0;
  assign stp_state = cur_stp[{fid_sel, 1'b0} +: 2];
  assign type_ok   = (cur_acc == 2'd1) ? in_tagged :
                     (cur_acc == 2'd2) ? !in_tagged : 1'b1;

  always_comb begin
    case (cur_mode)
      2'd1: begin
        cand    = found ? tbl_members : cur_mtx;
        vlan_ok = 1'b1;
      end
      2'd3: begin
        cand    = tbl_members;
        vlan_ok = found & member;
      end
      default: begin
        cand    = cur_mtx;
        vlan_ok = 1'b1;
      end
    endcase
  end

  assign final_map = cand & ~(NPORTS'(1) << in_port);

  always_comb begin
    if (!type_ok)               reason = RSN_TYPE;
    else if (!vlan_ok)          reason = RSN_VLAN;
    else if (stp_state != 2'd3) reason = RSN_STP;
    else if (final_map == '0)   reason = RSN_VLAN;
    else                        reason = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      drop        <= 1'b0;
      drop_reason <= RSN_NONE;
      dest_map    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        drop        <= (reason != RSN_NONE);
        drop_reason <= reason;
        dest_map    <= (reason != RSN_NONE) ? '0 : final_map;
      end
    end
  end
endmodule

module vlan_ingress_filter_chk #(
  parameter int NPORTS = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [$clog2(NPORTS)-1:0] in_port,
  input logic                      out_valid,
  input logic                      drop,
  input logic [1:0]                drop_reason,
  input logic [NPORTS-1:0]         dest_map
);
  assert_decision_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_drop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && drop) |-> (dest_map == '0 && drop_reason != 2'd0));

  assert_forward_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !drop) |-> (dest_map != '0 && drop_reason == 2'd0));

  assert_no_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !dest_map[$past(in_port)]);
endmodule

bind vlan_ingress_filter vlan_ingress_filter_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
  .out_valid(out_valid), .drop(drop), .drop_reason(drop_reason),
  .dest_map(dest_map)
);

// File: tb/vlan_ingress_filter_bench.sv
`timescale 1ns/1ps
module vlan_ingress_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_port = '0, cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic in_valid = 1'b0, in_tagged = 1'b0;
  logic [2:0] in_port = '0;
  logic [11:0] in_vid = '0, lookup_vid;
  logic tbl_hit = 1'b0, tbl_entry_valid = 1'b0;
  logic [7:0] tbl_members = '0;
  logic [2:0] tbl_fid = '0;
  logic out_valid, drop;
  logic [1:0] drop_reason;
  logic [7:0] dest_map;

  always #2.5 clk = ~clk;

  vlan_ingress_filter u_vlan_ingress_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port(cfg_port),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_port(in_port), .in_tagged(in_tagged), .in_vid(in_vid),
    .lookup_vid(lookup_vid), .tbl_hit(tbl_hit),
    .tbl_entry_valid(tbl_entry_valid), .tbl_members(tbl_members),
    .tbl_fid(tbl_fid), .out_valid(out_valid), .drop(drop),
    .drop_reason(drop_reason), .dest_map(dest_map)
  );

  typedef struct {
    logic       d;
    logic [1:0] r;
    logic [7:0] m;
    string      tag;
  } exp_t;

  exp_t exq[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic        pend = 1'b0;
  logic [2:0]  pend_port, pend_sel;
  logic [15:0] pend_data;

  task automatic chk(input bit ok, input string tag, input string got, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] p, input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_port = p; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame(input logic [2:0] p, input logic tg, input logic [11:0] vid,
                       input logic hit, input logic ev, input logic [7:0] mem,
                       input logic [2:0] fid, input logic [11:0] evid,
                       input logic ed, input logic [1:0] er, input logic [7:0] em,
                       input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_port = p; in_tagged = tg; in_vid = vid;
    tbl_hit = hit; tbl_entry_valid = ev; tbl_members = mem; tbl_fid = fid;
    if (pend) begin
      cfg_we = 1'b1; cfg_port = pend_port; cfg_sel = pend_sel; cfg_data = pend_data;
      pend = 1'b0;
    end
    e.d = ed; e.r = er; e.m = em; e.tag = tag;
    exq.push_back(e);
    #1;
    chk(lookup_vid == evid, {tag, " lookup_vid R2"},
        $sformatf("%h", lookup_vid), $sformatf("%h", evid));
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exq.size() == 0) begin
        chk(1'b0, "R2 unexpected decision", "out_valid=1", "out_valid=0");
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk(drop == e.d && drop_reason == e.r && dest_map == e.m, e.tag,
            $sformatf("drop=%0d reason=%0d map=%h", drop, drop_reason, dest_map),
            $sformatf("drop=%0d reason=%0d map=%h", e.d, e.r, e.m));
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", "completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 0 && drop == 0 && drop_reason == 0 && dest_map == 0,
        "R1 reset outputs", $sformatf("%b%b%0d%h", out_valid, drop, drop_reason, dest_map), "0000");

    // R1 defaults: matrix all ones, forwarding everywhere, pvid 0
    frame(3'd7, 1'b1, 12'h00A, 1'b1, 1'b1, 8'h0F, 3'd5, 12'h00A, 0, 0, 8'h7F, "R1 default matrix");
    frame(3'd7, 1'b0, 12'h0AB, 1'b0, 1'b0, 8'h00, 3'd0, 12'h000, 0, 0, 8'h7F, "R1 default pvid");

    // R4 matrix mode ignores table
    frame(3'd2, 1'b1, 12'h005, 1'b1, 1'b1, 8'h0F, 3'd1, 12'h005, 0, 0, 8'hFB, "R4 matrix hit");
    cfg(3'd2, 3'd2, 16'h0123);
    frame(3'd2, 1'b0, 12'h007, 1'b0, 1'b0, 8'h00, 3'd0, 12'h123, 0, 0, 8'hFB, "R2 untagged pvid");
    frame(3'd2, 1'b1, 12'h456, 1'b1, 1'b1, 8'h01, 3'd0, 12'h456, 0, 0, 8'hFB, "R2 tagged vid");

    // R3 frame type
    cfg(3'd1, 3'd3, 16'd1);
    frame(3'd1, 1'b0, 12'h000, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h000, 1, 1, 8'h00, "R3 untagged refused");
    frame(3'd1, 1'b1, 12'h010, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h010, 0, 0, 8'hFD, "R3 tagged accepted");
    cfg(3'd1, 3'd3, 16'd2);
    frame(3'd1, 1'b1, 12'h010, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h010, 1, 1, 8'h00, "R3 tagged refused");
    frame(3'd1, 1'b0, 12'h010, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h000, 0, 0, 8'hFD, "R3 untagged accepted");
    cfg(3'd1, 3'd3, 16'd3);
    frame(3'd1, 1'b1, 12'h010, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h010, 0, 0, 8'hFD, "R3 rule 3 accepts");

    // R5 fallback
    cfg(3'd3, 3'd0, 16'd1);
    cfg(3'd3, 3'd1, 16'h003C);
    frame(3'd3, 1'b1, 12'h020, 1'b1, 1'b1, 8'h05, 3'd2, 12'h020, 0, 0, 8'h05, "R5 non-member forwarded");
    frame(3'd3, 1'b1, 12'h021, 1'b0, 1'b1, 8'h05, 3'd2, 12'h021, 0, 0, 8'h34, "R5 miss to matrix");
    frame(3'd3, 1'b1, 12'h022, 1'b1, 1'b0, 8'h05, 3'd2, 12'h022, 0, 0, 8'h34, "R5 invalid entry is miss R7");

    // R6 security
    cfg(3'd4, 3'd0, 16'd3);
    frame(3'd4, 1'b1, 12'h030, 1'b1, 1'b1, 8'h31, 3'd1, 12'h030, 0, 0, 8'h21, "R6 member forwarded");
    frame(3'd4, 1'b1, 12'h030, 1'b1, 1'b1, 8'h03, 3'd1, 12'h030, 1, 2, 8'h00, "R6 violation drop");
    frame(3'd4, 1'b1, 12'h031, 1'b0, 1'b0, 8'h31, 3'd1, 12'h031, 1, 2, 8'h00, "R6 miss drop");

    // R7 spanning tree
    cfg(3'd5, 3'd4, 16'hFFEF);
    frame(3'd5, 1'b1, 12'h040, 1'b1, 1'b1, 8'hFF, 3'd2, 12'h040, 1, 3, 8'h00, "R7 learning blocks");
    frame(3'd5, 1'b1, 12'h040, 1'b1, 1'b1, 8'hFF, 3'd1, 12'h040, 0, 0, 8'hDF, "R7 other fid forwards");
    cfg(3'd6, 3'd0, 16'd1);
    cfg(3'd6, 3'd4, 16'hFFFC);
    frame(3'd6, 1'b1, 12'h050, 1'b0, 1'b0, 8'h00, 3'd7, 12'h050, 1, 3, 8'h00, "R7 miss uses fid 0");
    frame(3'd6, 1'b1, 12'h050, 1'b1, 1'b1, 8'h81, 3'd7, 12'h050, 0, 0, 8'h81, "R7 fid 7 forwards");

    // R8 self removal and empty map
    cfg(3'd0, 3'd0, 16'd3);
    frame(3'd0, 1'b1, 12'h060, 1'b1, 1'b1, 8'h01, 3'd0, 12'h060, 1, 2, 8'h00, "R8 only self member");
    cfg(3'd0, 3'd0, 16'd0);
    cfg(3'd0, 3'd1, 16'h0001);
    frame(3'd0, 1'b1, 12'h060, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h060, 1, 2, 8'h00, "R8 matrix only self");

    // R9 priority
    cfg(3'd1, 3'd0, 16'd3);
    cfg(3'd1, 3'd4, 16'h0000);
    cfg(3'd1, 3'd3, 16'd1);
    frame(3'd1, 1'b0, 12'h070, 1'b0, 1'b0, 8'h00, 3'd0, 12'h000, 1, 1, 8'h00, "R9 type beats all");
    frame(3'd1, 1'b1, 12'h070, 1'b0, 1'b0, 8'h00, 3'd0, 12'h070, 1, 2, 8'h00, "R9 miss beats stp");
    frame(3'd1, 1'b1, 12'h070, 1'b1, 1'b1, 8'hFF, 3'd0, 12'h070, 1, 3, 8'h00, "R9 stp last");

    // R10 write on the same edge as a frame
    pend = 1'b1; pend_port = 3'd7; pend_sel = 3'd0; pend_data = 16'd3;
    frame(3'd7, 1'b1, 12'h080, 1'b0, 1'b0, 8'h00, 3'd0, 12'h080, 0, 0, 8'h7F, "R10 old mode used");
    frame(3'd7, 1'b1, 12'h080, 1'b0, 1'b0, 8'h00, 3'd0, 12'h080, 1, 2, 8'h00, "R10 new mode next frame");
    cfg(3'd7, 3'd0, 16'd2);
    frame(3'd7, 1'b1, 12'h081, 1'b1, 1'b1, 8'h03, 3'd0, 12'h081, 0, 0, 8'h7F, "R4 reserved mode as matrix");

    repeat (3) @(negedge clk);
    chk(exq.size() == 0, "R2 all decisions seen", $sformatf("%0d", exq.size()), "0");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule